// File: doc/BRIEF.md
# Packet Buffer SRAM Partition Controller

This block sits between a network MAC, a DMA engine and a single-port on-chip SRAM that extends the packet FIFOs. Software programs a total SRAM size and a transmit/receive boundary, both in 512-byte pages. The block then keeps one circular transmit region and one circular receive region, generates their SRAM addresses, and reports full and empty for each. A fixed-priority arbiter grants at most one SRAM access per cycle. Read data comes back one cycle after the grant.

Three layouts are chosen from the programmed settings:
- **Split mode.** Both regions live in SRAM. Transmit occupies the pages below the boundary and receive occupies the pages from the boundary up to the size.
- **Bypass mode.** With a size of zero, two small internal FIFOs carry the traffic directly.
- **Low-latency receive mode.** Receive traffic goes through an internal FIFO and the whole SRAM serves transmit. The receive DMA request is raised early in each frame.

Settings written while the controller runs are kept in shadow registers. They only reach the active layout while the run flag is low. Dropping the run flag also flushes both paths and clears the error flags.

Top module: `pktbuf_partition`

## Requirements
- R1: After reset the mode output is 0 (bypass), both paths are empty and not full, `rx_ovf`, `tx_udf`, `cfg_err` and `dma_rx_req` are 0.
- R2: With an active size of 0 the mode is 0 (bypass) whatever the boundary is. Each direction uses a 16-entry first-in first-out buffer that never drives `sram_we` or `sram_re`.
- R3: A settings write made while `run` is 1 leaves `mode` and `cfg_err` unchanged. It takes effect at the first clock edge at which `run` is 0. Settings select codes: 0 = size in pages, 1 = boundary in pages, 2 = control with bit 0 = low-latency receive.
- R4: In split mode (mode 1) the transmit region covers byte addresses 0 to boundary*512-1 and the receive region covers boundary*512 to size*512-1. Each region is written and read from its base upward.
- R5: Each region is circular. It reports full after exactly its length in bytes has been written without a read, and the write following a wrap lands at the region base.
- R6: `rx_ovf` is set when the MAC offers a receive byte while the receive path is full. `tx_udf` is set when the MAC requests a transmit byte while the transmit path is empty. Neither request is granted. Both flags stay set until `run` goes to 0.
- R7: `cfg_err` is 1 in two cases: in split mode when either region has fewer than 4 pages or the boundary exceeds the size, and in low-latency mode when the size is under 4 pages. While it is 1, no request is granted to SRAM.
- R8: With control bit 0 set and a nonzero size the mode is 2 (low-latency). Receive bytes bypass the SRAM through a 16-entry buffer, the transmit region spans all size*512 bytes, and the boundary is ignored. With a size of 0 the control bit has no effect.
- R9: `dma_rx_req` rises once 16 bytes of the current frame have been accepted in mode 2, or 64 bytes in mode 1. It drops when a byte flagged start-of-frame is accepted.
- R10: SRAM priority is receive write, then transmit read, then receive read, then transmit write. At most one of `sram_we` and `sram_re` is high in a cycle.
- R11: A read granted at a clock edge presents its data with the matching valid strobe for the cycle after that edge.
- R12: While `run` is 0 no request is granted. At the first edge with `run` at 0 both paths become empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = controller running, 0 = stopped |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 2 | Settings select: 0 size, 1 boundary, 2 control |
| cfg_wdata | input | 8 | Settings write data |
| mac_rx_wr | input | 1 | MAC offers a receive byte |
| mac_rx_sof | input | 1 | Offered receive byte starts a frame |
| mac_rx_data | input | 8 | Receive byte from the MAC |
| mac_rx_gnt | output | 1 | Receive byte accepted this cycle |
| dma_rx_rd | input | 1 | DMA requests a receive byte |
| dma_rx_gnt | output | 1 | Receive read granted this cycle |
| dma_rx_vld | output | 1 | Receive read data valid |
| dma_rx_data | output | 8 | Receive read data |
| dma_rx_req | output | 1 | Receive DMA request after the frame threshold |
| dma_tx_wr | input | 1 | DMA offers a transmit byte |
| dma_tx_data | input | 8 | Transmit byte from DMA |
| dma_tx_gnt | output | 1 | Transmit byte accepted this cycle |
| mac_tx_rd | input | 1 | MAC requests a transmit byte |
| mac_tx_gnt | output | 1 | Transmit read granted this cycle |
| mac_tx_vld | output | 1 | Transmit read data valid |
| mac_tx_data | output | 8 | Transmit read data |
| sram_we | output | 1 | SRAM write strobe |
| sram_re | output | 1 | SRAM read strobe |
| sram_addr | output | 17 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, one cycle after `sram_re` |
| mode | output | 2 | Active layout: 0 bypass, 1 split, 2 low-latency |
| cfg_err | output | 1 | Active settings are invalid |
| rx_full | output | 1 | Receive path full |
| rx_empty | output | 1 | Receive path empty |
| tx_full | output | 1 | Transmit path full |
| tx_empty | output | 1 | Transmit path empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_udf | output | 1 | Sticky transmit underflow |

## Verification
The bench fills the receive region to exactly its byte count, then checks three things: the full flag rises on the last byte and not one byte earlier, the overflow flag is set, and the write after a read wraps to the boundary address. A design with an off-by-one region limit or a wrap to address 0 would corrupt transmit data.

It sets a boundary while the size is 0 and loads one while running, which exposes a design that lets an ignored or running-time setting leak into the layout. It drives colliding receive-write and transmit-write requests, and colliding read requests, to catch a wrong priority or a double SRAM access. It counts frame bytes across the 15/16 and 63/64 thresholds to catch a DMA request raised one byte early or with the wrong threshold for the mode.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SPLIT  = 2'd1,
    MODE_LOWLAT = 2'd2
  } buf_mode_e;

  typedef enum logic [1:0] {
    SEL_SIZE  = 2'd0,
    SEL_BOUND = 2'd1,
    SEL_CTRL  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/pbuf_cfg.sv
module pbuf_cfg
  import pbuf_pkg::*;
#(
  parameter int unsigned PG_W       = 8,
  parameter int unsigned PAGE_SHIFT = 9,
  parameter int unsigned MIN_PAGES  = 4,
  parameter int unsigned AW         = PG_W + PAGE_SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PG_W-1:0] cfg_wdata,
  output buf_mode_e       mode,
  output logic            cfg_err,
  output logic [AW-1:0]   tx_len,
  output logic [AW-1:0]   rx_base,
  output logic [AW-1:0]   rx_len
);
  logic [PG_W-1:0] sh_size_q, sh_size_d, sh_bnd_q, sh_bnd_d;
  logic            sh_ll_q, sh_ll_d;
  logic [PG_W-1:0] act_size_q, act_size_d, act_bnd_q, act_bnd_d;
  logic            act_ll_q, act_ll_d;
  logic [PG_W-1:0] rx_pages;

  // shadow registers accept writes at any time; the active copy follows only while stopped
  always_comb begin
    sh_size_d = sh_size_q;
    sh_bnd_d  = sh_bnd_q;
    sh_ll_d   = sh_ll_q;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_SIZE:  sh_size_d = cfg_wdata;
        SEL_BOUND: sh_bnd_d  = cfg_wdata;
        SEL_CTRL:  sh_ll_d   = cfg_wdata[0];
        default:   ;
      endcase
    end
    act_size_d = run ? act_size_q : sh_size_d;
    act_bnd_d  = run ? act_bnd_q  : sh_bnd_d;
    act_ll_d   = run ? act_ll_q   : sh_ll_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_size_q  <= '0;
      sh_bnd_q   <= '0;
      sh_ll_q    <= 1'b0;
      act_size_q <= '0;
      act_bnd_q  <= '0;
      act_ll_q   <= 1'b0;
    end else begin
      sh_size_q  <= sh_size_d;
      sh_bnd_q   <= sh_bnd_d;
      sh_ll_q    <= sh_ll_d;
      act_size_q <= act_size_d;
      act_bnd_q  <= act_bnd_d;
      act_ll_q   <= act_ll_d;
    end
  end

  assign rx_pages = act_size_q - act_bnd_q;
  assign rx_base  = {act_bnd_q, {PAGE_SHIFT{1'b0}}};

  always_comb begin
    if (act_size_q == '0)  mode = MODE_BYPASS;
    else if (act_ll_q)     mode = MODE_LOWLAT;
    else                   mode = MODE_SPLIT;
  end

  always_comb begin
    cfg_err = 1'b0;
    tx_len  = '0;
    rx_len  = '0;
    case (mode)
      MODE_SPLIT: begin
        cfg_err = (act_bnd_q > act_size_q) || (act_bnd_q < PG_W'(MIN_PAGES)) ||
                  (rx_pages < PG_W'(MIN_PAGES));
        if (!cfg_err) begin
          tx_len = {act_bnd_q, {PAGE_SHIFT{1'b0}}};
          rx_len = {rx_pages, {PAGE_SHIFT{1'b0}}};
        end
      end
      MODE_LOWLAT: begin
        cfg_err = act_size_q < PG_W'(MIN_PAGES);
        if (!cfg_err) tx_len = {act_size_q, {PAGE_SHIFT{1'b0}}};
      end
      default: ;
    endcase
  end

  // R3: layout frozen while running
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(mode) && $stable(cfg_err)));
endmodule

// File: rtl/pbuf_ring.sv
module pbuf_ring #(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic          push,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  logic [AW-1:0] wr_off_q, wr_off_d, rd_off_q, rd_off_d, last_off;
  logic          wr_wrap_q, wr_wrap_d, rd_wrap_q, rd_wrap_d;
  logic          no_space, same_off;

  assign last_off = len - {{(AW-1){1'b0}}, 1'b1};
  assign no_space = (len == '0);
  assign same_off = (wr_off_q == rd_off_q);
  assign empty    = no_space | (same_off & (wr_wrap_q == rd_wrap_q));
  assign full     = no_space | (same_off & (wr_wrap_q != rd_wrap_q));
  assign wr_addr  = base + wr_off_q;
  assign rd_addr  = base + rd_off_q;

  always_comb begin
    wr_off_d  = wr_off_q;
    wr_wrap_d = wr_wrap_q;
    rd_off_d  = rd_off_q;
    rd_wrap_d = rd_wrap_q;
    if (clr) begin
      wr_off_d  = '0;
      wr_wrap_d = 1'b0;
      rd_off_d  = '0;
      rd_wrap_d = 1'b0;
    end else begin
      if (push) begin
        if (wr_off_q == last_off) begin
          wr_off_d  = '0;
          wr_wrap_d = ~wr_wrap_q;
        end else begin
          wr_off_d = wr_off_q + 1'b1;
        end
      end
      if (pop) begin
        if (rd_off_q == last_off) begin
          rd_off_d  = '0;
          rd_wrap_d = ~rd_wrap_q;
        end else begin
          rd_off_d = rd_off_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off_q  <= '0;
      wr_wrap_q <= 1'b0;
      rd_off_q  <= '0;
      rd_wrap_q <= 1'b0;
    end else begin
      wr_off_q  <= wr_off_d;
      wr_wrap_q <= wr_wrap_d;
      rd_off_q  <= rd_off_d;
      rd_wrap_q <= rd_wrap_d;
    end
  end

  // R5: the arbiter never pushes into a full region nor pops an empty one
  p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_pop_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R5: the write after the last byte of the region returns to the base
  p_wrap_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && (wr_off_q == last_off)) |=> (wr_addr == base));
endmodule

// File: rtl/pbuf_fifo.sv
module pbuf_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wp_q, wp_d, rp_q, rp_d;
  logic [DW-1:0] rdata_q, rdata_d;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[PW-1:0] == rp_q[PW-1:0]) && (wp_q[PW] != rp_q[PW]);
  assign rdata = rdata_q;

  always_comb begin
    wp_d    = clr ? '0 : wp_q + {{PW{1'b0}}, push};
    rp_d    = clr ? '0 : rp_q + {{PW{1'b0}}, pop};
    rdata_d = pop ? mem[rp_q[PW-1:0]] : rdata_q;
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp_q[PW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      rdata_q <= '0;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      rdata_q <= rdata_d;
    end
  end

  // R2: bypass buffers are never over- or under-run
  p_fifo_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_fifo_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/pktbuf_partition.sv
module pktbuf_partition
  import pbuf_pkg::*;
#(
  parameter int unsigned PG_W       = 8,
  parameter int unsigned PAGE_SHIFT = 9,
  parameter int unsigned MIN_PAGES  = 4,
  parameter int unsigned DW         = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LL_THRESH  = 16,
  parameter int unsigned STD_THRESH = 64,
  localparam int unsigned AW        = PG_W + PAGE_SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PG_W-1:0] cfg_wdata,
  input  logic            mac_rx_wr,
  input  logic            mac_rx_sof,
  input  logic [DW-1:0]   mac_rx_data,
  output logic            mac_rx_gnt,
  input  logic            dma_rx_rd,
  output logic            dma_rx_gnt,
  output logic            dma_rx_vld,
  output logic [DW-1:0]   dma_rx_data,
  output logic            dma_rx_req,
  input  logic            dma_tx_wr,
  input  logic [DW-1:0]   dma_tx_data,
  output logic            dma_tx_gnt,
  input  logic            mac_tx_rd,
  output logic            mac_tx_gnt,
  output logic            mac_tx_vld,
  output logic [DW-1:0]   mac_tx_data,
  output logic            sram_we,
  output logic            sram_re,
  output logic [AW-1:0]   sram_addr,
  output logic [DW-1:0]   sram_wdata,
  input  logic [DW-1:0]   sram_rdata,
  output logic [1:0]      mode,
  output logic            cfg_err,
  output logic            rx_full,
  output logic            rx_empty,
  output logic            tx_full,
  output logic            tx_empty,
  output logic            rx_ovf,
  output logic            tx_udf
);
  localparam int unsigned THR_MAX = (LL_THRESH > STD_THRESH) ? LL_THRESH : STD_THRESH;
  localparam int unsigned CNT_W   = $clog2(THR_MAX + 1);

  buf_mode_e     cur_mode;
  logic [AW-1:0] tx_len, rx_base, rx_len;
  logic          clr, rx_in_sram, tx_in_sram;
  logic          ring_rx_full, ring_rx_empty, ring_tx_full, ring_tx_empty;
  logic          fifo_rx_full, fifo_rx_empty, fifo_tx_full, fifo_tx_empty;
  logic [AW-1:0] rx_wr_addr, rx_rd_addr, tx_wr_addr, tx_rd_addr;
  logic [DW-1:0] fifo_rx_q, fifo_tx_q;
  logic          req_rxw, req_txr, req_rxr, req_txw;
  logic          g_rxw, g_txr, g_rxr, g_txw, busy0, busy1, busy2;
  logic          rx_vld_q, rx_src_q, tx_vld_q, tx_src_q;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic [CNT_W-1:0] frm_cnt_q, frm_cnt_d;

  pbuf_cfg #(.PG_W(PG_W), .PAGE_SHIFT(PAGE_SHIFT), .MIN_PAGES(MIN_PAGES), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode(cur_mode), .cfg_err(cfg_err),
    .tx_len(tx_len), .rx_base(rx_base), .rx_len(rx_len)
  );

  assign clr        = ~run;
  assign mode       = cur_mode;
  assign rx_in_sram = (cur_mode == MODE_SPLIT);
  assign tx_in_sram = (cur_mode == MODE_SPLIT) || (cur_mode == MODE_LOWLAT);

  assign rx_full  = rx_in_sram ? ring_rx_full  : fifo_rx_full;
  assign rx_empty = rx_in_sram ? ring_rx_empty : fifo_rx_empty;
  assign tx_full  = tx_in_sram ? ring_tx_full  : fifo_tx_full;
  assign tx_empty = tx_in_sram ? ring_tx_empty : fifo_tx_empty;

  // eligible requests, then fixed-priority grant among those that map to SRAM
  assign req_rxw = run & mac_rx_wr & ~rx_full;
  assign req_txr = run & mac_tx_rd & ~tx_empty;
  assign req_rxr = run & dma_rx_rd & ~rx_empty;
  assign req_txw = run & dma_tx_wr & ~tx_full;

  assign g_rxw = req_rxw;
  assign busy0 = rx_in_sram & g_rxw;
  assign g_txr = req_txr & ~(tx_in_sram & busy0);
  assign busy1 = busy0 | (tx_in_sram & g_txr);
  assign g_rxr = req_rxr & ~(rx_in_sram & busy1);
  assign busy2 = busy1 | (rx_in_sram & g_rxr);
  assign g_txw = req_txw & ~(tx_in_sram & busy2);

  assign mac_rx_gnt = g_rxw;
  assign mac_tx_gnt = g_txr;
  assign dma_rx_gnt = g_rxr;
  assign dma_tx_gnt = g_txw;

  assign sram_we = (rx_in_sram & g_rxw) | (tx_in_sram & g_txw);
  assign sram_re = (tx_in_sram & g_txr) | (rx_in_sram & g_rxr);

  always_comb begin
    sram_addr  = '0;
    sram_wdata = '0;
    if (rx_in_sram && g_rxw) begin
      sram_addr  = rx_wr_addr;
      sram_wdata = mac_rx_data;
    end else if (tx_in_sram && g_txr) begin
      sram_addr = tx_rd_addr;
    end else if (rx_in_sram && g_rxr) begin
      sram_addr = rx_rd_addr;
    end else if (tx_in_sram && g_txw) begin
      sram_addr  = tx_wr_addr;
      sram_wdata = dma_tx_data;
    end
  end

  pbuf_ring #(.AW(AW)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr), .base(rx_base), .len(rx_len),
    .push(rx_in_sram & g_rxw), .pop(rx_in_sram & g_rxr),
    .full(ring_rx_full), .empty(ring_rx_empty),
    .wr_addr(rx_wr_addr), .rd_addr(rx_rd_addr)
  );

  pbuf_ring #(.AW(AW)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr), .base('0), .len(tx_len),
    .push(tx_in_sram & g_txw), .pop(tx_in_sram & g_txr),
    .full(ring_tx_full), .empty(ring_tx_empty),
    .wr_addr(tx_wr_addr), .rd_addr(tx_rd_addr)
  );

  pbuf_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(~rx_in_sram & g_rxw), .wdata(mac_rx_data),
    .pop(~rx_in_sram & g_rxr), .rdata(fifo_rx_q),
    .full(fifo_rx_full), .empty(fifo_rx_empty)
  );

  pbuf_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(~tx_in_sram & g_txw), .wdata(dma_tx_data),
    .pop(~tx_in_sram & g_txr), .rdata(fifo_tx_q),
    .full(fifo_tx_full), .empty(fifo_tx_empty)
  );

  // sticky error flags and frame byte counter
  always_comb begin
    ovf_d = clr ? 1'b0 : (ovf_q | (mac_rx_wr & rx_full));
    udf_d = clr ? 1'b0 : (udf_q | (mac_tx_rd & tx_empty));
    frm_cnt_d = frm_cnt_q;
    if (clr) begin
      frm_cnt_d = '0;
    end else if (g_rxw) begin
      if (mac_rx_sof)                             frm_cnt_d = CNT_W'(1);
      else if (frm_cnt_q != CNT_W'(THR_MAX))      frm_cnt_d = frm_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_vld_q  <= 1'b0;
      rx_src_q  <= 1'b0;
      tx_vld_q  <= 1'b0;
      tx_src_q  <= 1'b0;
      ovf_q     <= 1'b0;
      udf_q     <= 1'b0;
      frm_cnt_q <= '0;
    end else begin
      rx_vld_q  <= g_rxr;
      rx_src_q  <= rx_in_sram;
      tx_vld_q  <= g_txr;
      tx_src_q  <= tx_in_sram;
      ovf_q     <= ovf_d;
      udf_q     <= udf_d;
      frm_cnt_q <= frm_cnt_d;
    end
  end

  assign dma_rx_vld  = rx_vld_q;
  assign dma_rx_data = rx_src_q ? sram_rdata : fifo_rx_q;
  assign mac_tx_vld  = tx_vld_q;
  assign mac_tx_data = tx_src_q ? sram_rdata : fifo_tx_q;
  assign rx_ovf      = ovf_q;
  assign tx_udf      = udf_q;
  assign dma_rx_req  = (cur_mode == MODE_LOWLAT) ? (frm_cnt_q >= CNT_W'(LL_THRESH))
                                                 : (frm_cnt_q >= CNT_W'(STD_THRESH));

  // R10: single SRAM access per cycle
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_we && sram_re));
  // R7: invalid layout never reaches SRAM
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!sram_we && !sram_re));
  // R2: bypass layout never reaches SRAM
  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_BYPASS) |-> (!sram_we && !sram_re));
  // R11: granted reads return data in the next cycle
  p_rx_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_gnt |=> dma_rx_vld);
  p_tx_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mac_tx_gnt |=> mac_tx_vld);
  // R6: a full receive path accepts nothing and records the overflow
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mac_rx_wr && rx_full) |=> (rx_ovf || !run));
  // R12: stopped means nothing granted
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(mac_rx_gnt || dma_rx_gnt || dma_tx_gnt || mac_tx_gnt));
endmodule

// File: tb/pktbuf_partition_tb.sv
module pktbuf_partition_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        mac_rx_wr, mac_rx_sof;
  logic [7:0]  mac_rx_data;
  logic        mac_rx_gnt;
  logic        dma_rx_rd, dma_rx_gnt, dma_rx_vld, dma_rx_req;
  logic [7:0]  dma_rx_data;
  logic        dma_tx_wr, dma_tx_gnt;
  logic [7:0]  dma_tx_data;
  logic        mac_tx_rd, mac_tx_gnt, mac_tx_vld;
  logic [7:0]  mac_tx_data;
  logic        sram_we, sram_re;
  logic [16:0] sram_addr;
  logic [7:0]  sram_wdata;
  logic [7:0]  sram_rdata;
  logic [1:0]  mode;
  logic        cfg_err, rx_full, rx_empty, tx_full, tx_empty, rx_ovf, tx_udf;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] sram_mem [4096];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (sram_we) sram_mem[sram_addr[11:0]] <= sram_wdata;
    if (sram_re) sram_rdata <= sram_mem[sram_addr[11:0]];
  end

  pktbuf_partition u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mac_rx_wr(mac_rx_wr), .mac_rx_sof(mac_rx_sof),
    .mac_rx_data(mac_rx_data), .mac_rx_gnt(mac_rx_gnt), .dma_rx_rd(dma_rx_rd),
    .dma_rx_gnt(dma_rx_gnt), .dma_rx_vld(dma_rx_vld), .dma_rx_data(dma_rx_data),
    .dma_rx_req(dma_rx_req), .dma_tx_wr(dma_tx_wr), .dma_tx_data(dma_tx_data),
    .dma_tx_gnt(dma_tx_gnt), .mac_tx_rd(mac_tx_rd), .mac_tx_gnt(mac_tx_gnt),
    .mac_tx_vld(mac_tx_vld), .mac_tx_data(mac_tx_data), .sram_we(sram_we),
    .sram_re(sram_re), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .mode(mode), .cfg_err(cfg_err), .rx_full(rx_full),
    .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_ovf(rx_ovf), .tx_udf(tx_udf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end 1 ns after a rising edge
  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_run(input logic v);
    run = v;
    @(posedge clk); #1;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic sof,
                         output logic g, output logic we, output logic [16:0] a);
    mac_rx_wr = 1'b1; mac_rx_data = d; mac_rx_sof = sof;
    @(negedge clk);
    g = mac_rx_gnt; we = sram_we; a = sram_addr;
    @(posedge clk); #1;
    mac_rx_wr = 1'b0; mac_rx_sof = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d, output logic g, output logic [16:0] a);
    dma_tx_wr = 1'b1; dma_tx_data = d;
    @(negedge clk);
    g = dma_tx_gnt; a = sram_addr;
    @(posedge clk); #1;
    dma_tx_wr = 1'b0;
  endtask

  task automatic rx_pop(output logic g, output logic [16:0] a,
                        output logic v, output logic [7:0] d);
    dma_rx_rd = 1'b1;
    @(negedge clk);
    g = dma_rx_gnt; a = sram_addr;
    @(posedge clk); #1;
    dma_rx_rd = 1'b0;
    v = dma_rx_vld; d = dma_rx_data;
  endtask

  task automatic tx_pop(output logic g, output logic [16:0] a,
                        output logic v, output logic [7:0] d);
    mac_tx_rd = 1'b1;
    @(negedge clk);
    g = mac_tx_gnt; a = sram_addr;
    @(posedge clk); #1;
    mac_tx_rd = 1'b0;
    v = mac_tx_vld; d = mac_tx_data;
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 flags", {rx_ovf, tx_udf, dma_rx_req}, 0);
  endtask

  task automatic t_bypass;
    logic g, we, v; logic [16:0] a; logic [7:0] d;
    cfg_write(2'd1, 8'd5);
    chk("R2 boundary ignored mode", mode, 0);
    chk("R2 boundary ignored err", cfg_err, 0);
    set_run(1'b1);
    for (int i = 0; i < 3; i++) begin
      rx_push(8'hA0 + 8'(i), i == 0, g, we, a);
      chk("R2 rx push gnt", g, 1);
      chk("R2 rx push no sram", we, 0);
    end
    for (int i = 0; i < 3; i++) begin
      rx_pop(g, a, v, d);
      chk("R11 rx pop vld", v, 1);
      chk("R2 rx fifo order", d, 8'hA0 + 8'(i));
    end
    tx_push(8'h5A, g, a);
    chk("R2 tx push gnt", g, 1);
    tx_pop(g, a, v, d);
    chk("R11 tx pop data", {v, d}, {1'b1, 8'h5A});
    for (int i = 0; i < 16; i++) begin
      rx_push(8'(i), 1'b0, g, we, a);
      if (i == 14) chk("R2 not full at 15", rx_full, 0);
    end
    chk("R2 full at 16", rx_full, 1);
    rx_push(8'hFF, 1'b0, g, we, a);
    chk("R6 overflow not granted", g, 0);
    chk("R6 overflow flag", rx_ovf, 1);
    set_run(1'b0);
    chk("R12 flush empty", rx_empty, 1);
    chk("R6 flag cleared on stop", rx_ovf, 0);
  endtask

  task automatic t_hold;
    set_run(1'b1);
    cfg_write(2'd0, 8'd8);
    cfg_write(2'd1, 8'd4);
    @(posedge clk); #1;
    chk("R3 held while running", mode, 0);
    set_run(1'b0);
    chk("R3 applied on stop", mode, 1);
    chk("R3 applied err", cfg_err, 0);
  endtask

  task automatic t_split;
    logic g, we, v; logic [16:0] a; logic [7:0] d;
    set_run(1'b1);
    tx_push(8'h11, g, a);
    chk("R4 tx first addr", {g, a}, {1'b1, 17'd0});
    tx_push(8'h22, g, a);
    chk("R4 tx second addr", a, 17'd1);
    rx_push(8'h33, 1'b1, g, we, a);
    chk("R4 rx base addr", {g, we, a}, {2'b11, 17'd2048});
    // receive write beats transmit write
    mac_rx_wr = 1'b1; mac_rx_data = 8'h44; dma_tx_wr = 1'b1; dma_tx_data = 8'h55;
    @(negedge clk);
    chk("R10 rx write wins", {mac_rx_gnt, dma_tx_gnt}, 2'b10);
    chk("R10 rx write addr", {sram_addr, sram_wdata}, {17'd2049, 8'h44});
    @(posedge clk); #1;
    mac_rx_wr = 1'b0;
    @(negedge clk);
    chk("R10 held tx write granted next", {dma_tx_gnt, sram_addr}, {1'b1, 17'd2});
    @(posedge clk); #1;
    dma_tx_wr = 1'b0;
    // transmit read beats receive read
    mac_tx_rd = 1'b1; dma_rx_rd = 1'b1;
    @(negedge clk);
    chk("R10 tx read wins", {mac_tx_gnt, dma_rx_gnt, sram_re}, 3'b101);
    chk("R10 tx read addr", sram_addr, 17'd0);
    @(posedge clk); #1;
    mac_tx_rd = 1'b0; dma_rx_rd = 1'b0;
    chk("R11 tx data next cycle", {mac_tx_vld, mac_tx_data, dma_rx_vld}, {1'b1, 8'h11, 1'b0});
    rx_pop(g, a, v, d);
    chk("R4 rx read addr", a, 17'd2048);
    chk("R11 rx data", {v, d}, {1'b1, 8'h33});
    set_run(1'b0);
  endtask

  task automatic t_wrap;
    logic g, we, v; logic [16:0] a; logic [7:0] d;
    set_run(1'b1);
    for (int i = 0; i < 2048; i++) begin
      rx_push(8'(i), i == 0, g, we, a);
      if (i == 62)   chk("R9 no req at 63 bytes", dma_rx_req, 0);
      if (i == 63)   chk("R9 req at 64 bytes", dma_rx_req, 1);
      if (i == 2046) chk("R5 not full one short", rx_full, 0);
    end
    chk("R5 full at region length", rx_full, 1);
    rx_push(8'hEE, 1'b0, g, we, a);
    chk("R6 push into full not granted", g, 0);
    chk("R6 overflow set", rx_ovf, 1);
    rx_pop(g, a, v, d);
    chk("R5 pop addr", {a, d}, {17'd2048, 8'h00});
    rx_push(8'hAB, 1'b0, g, we, a);
    chk("R5 wrap to base", {g, a}, {1'b1, 17'd2048});
    chk("R5 full again", rx_full, 1);
    tx_pop(g, a, v, d);
    chk("R6 empty read not granted", g, 0);
    chk("R6 underflow set", tx_udf, 1);
    set_run(1'b0);
    chk("R12 stop clears flags", {rx_ovf, tx_udf}, 2'b00);
    chk("R12 stop empties", {rx_empty, tx_empty}, 2'b11);
  endtask

  task automatic t_err;
    logic g, we; logic [16:0] a;
    cfg_write(2'd0, 8'd6); cfg_write(2'd1, 8'd3);
    chk("R7 tx too small", cfg_err, 1);
    set_run(1'b1);
    rx_push(8'h01, 1'b1, g, we, a);
    chk("R7 no access in error", {g, we}, 2'b00);
    set_run(1'b0);
    cfg_write(2'd0, 8'd7); cfg_write(2'd1, 8'd4);
    chk("R7 rx too small", cfg_err, 1);
    cfg_write(2'd0, 8'd3); cfg_write(2'd1, 8'd5);
    chk("R7 boundary above size", cfg_err, 1);
    cfg_write(2'd0, 8'd8); cfg_write(2'd1, 8'd4);
    chk("R7 minimum valid", cfg_err, 0);
    cfg_write(2'd2, 8'd1); cfg_write(2'd0, 8'd3);
    chk("R7 low-latency too small", cfg_err, 1);
  endtask

  task automatic t_lowlat;
    logic g, we, v; logic [16:0] a; logic [7:0] d;
    cfg_write(2'd0, 8'd4); cfg_write(2'd1, 8'd0);
    chk("R8 mode low-latency", mode, 2);
    chk("R8 boundary ignored", cfg_err, 0);
    set_run(1'b1);
    for (int i = 0; i < 16; i++) begin
      rx_push(8'hC0 + 8'(i), i == 0, g, we, a);
      if (i == 0)  chk("R8 rx bypasses sram", {g, we}, 2'b10);
      if (i == 14) chk("R9 no req at 15 bytes", dma_rx_req, 0);
    end
    chk("R9 req at 16 bytes", dma_rx_req, 1);
    rx_pop(g, a, v, d);
    chk("R8 rx fifo data", {v, d}, {1'b1, 8'hC0});
    rx_push(8'h99, 1'b1, g, we, a);
    chk("R9 req drops at new frame", dma_rx_req, 0);
    for (int i = 0; i < 2048; i++) begin
      tx_push(8'(i), g, a);
      if (i == 2046) chk("R8 tx not full one short", tx_full, 0);
      if (i == 2047) chk("R8 tx spans whole sram", {g, a}, {1'b1, 17'd2047});
    end
    chk("R8 tx full", tx_full, 1);
    set_run(1'b0);
    cfg_write(2'd0, 8'd0);
    chk("R8 control bit ignored at size 0", mode, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    mac_rx_wr = 1'b0; mac_rx_sof = 1'b0; mac_rx_data = '0; dma_rx_rd = 1'b0;
    dma_tx_wr = 1'b0; dma_tx_data = '0; mac_tx_rd = 1'b0; sram_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_bypass();
    t_hold();
    t_split();
    t_wrap();
    t_err();
    t_lowlat();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule